// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a processor datapath that takes several clock cycles per instruction and shares one memory between instruction fetch and data access. It walks through ten numbered states. Each state drives a fixed set of datapath control lines: the program-counter write enables, the memory address source and strobes, the instruction-register load, ALU operand and operation selects, and the register-file write controls.

The only data input is the 6-bit opcode held in the instruction register. The sequencer reads it in the decode state and, for memory instructions, once more in the address state. Loads take five cycles, stores and register-register operations four, and branches and jumps three. The control outputs are a Moore function of the current state, which is also exposed as a 4-bit number. All pins are plain level signals with no handshake, because the datapath consumes the controls in the same cycle they are driven.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low, the state is 0 and the outputs hold the fetch vector. The state register is 4 bits wide.
- R2: State 0 drives `mem_rd`=1, `ir_wr`=1, `pc_wr`=1, `addr_sel_alu`=0, `alu_a_sel`=0, `alu_b_sel`=01, `alu_mode`=00 and `pc_sel`=00. The next state is always 1.
- R3: State 1 drives `alu_a_sel`=0, `alu_b_sel`=11 and `alu_mode`=00. The next state is chosen by opcode: 0x23 (load) or 0x2B (store) go to 2, 0x00 (register operation) goes to 6, 0x04 (branch if equal) goes to 8, and 0x02 (jump) goes to 9.
- R4: State 2 drives `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. It goes to 3 for opcode 0x23, to 5 for opcode 0x2B, and to 0 for any other opcode.
- R5: State 3 drives `mem_rd`=1 with `addr_sel_alu`=1 and goes to 4. State 4 drives `rf_wr`=1, `rf_dst_rd`=0 and `wb_from_mem`=1, then goes to 0.
- R6: State 5 drives `mem_wr`=1 with `addr_sel_alu`=1, then goes to 0.
- R7: State 6 drives `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10, then goes to 7. State 7 drives `rf_wr`=1, `rf_dst_rd`=1 and `wb_from_mem`=0, then goes to 0.
- R8: State 8 drives `alu_a_sel`=1, `alu_b_sel`=00, `alu_mode`=01, `pc_wr_cond`=1 and `pc_sel`=01. State 9 drives `pc_wr`=1 and `pc_sel`=10. Both go to 0. `pc_wr` is high only in states 0 and 9.
- R9: In state 1, an opcode outside the five listed values leads to state 0. No write strobe is asserted in state 1.
- R10: Measured from one visit of state 0 to the next, a load takes 5 cycles, a store 4, a register operation 4, a branch 3, a jump 3, and an unrecognised opcode 2.
- R11: Any control output that a state does not list is 0. At most one of `ir_wr`, `mem_wr` and `rf_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_wr | output | 1 | Unconditional program-counter write |
| pc_wr_cond | output | 1 | Program-counter write qualified by ALU zero |
| addr_sel_alu | output | 1 | Memory address from the ALU result register (1) or the PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction-register load |
| wb_from_mem | output | 1 | Register write data from the memory data register (1) or the ALU result (0) |
| pc_sel | output | 2 | Next-PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation class: 00 add, 01 subtract, 10 function field |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU second operand: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register-file write strobe |
| rf_dst_rd | output | 1 | Write to the rd field (1) or the rt field (0) |
| state_o | output | 4 | Current state number, 0 to 9 |

## Verification
The assertions assume that `opcode` carries a known 2-state value whenever the sequencer samples it, that is in states 1 and 2. They also assume the opcode has not changed since decode when a memory instruction reaches the address state. The bench drives a new opcode only while the sequencer is in fetch, always as a defined value, and holds it until the next fetch. It picks opcodes with a seeded `$urandom`, mixing the five legal values with arbitrary 6-bit values that reach the unrecognised path. A directed prologue covers each legal opcode and two illegal ones first.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int unsigned ST_BITS = 4;

  typedef enum logic [ST_BITS-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_MWB    = 4'd4,
    S_MWRITE = 4'd5,
    S_EXEC   = 4'd6,
    S_RDONE  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9
  } st_e;

  typedef enum logic [2:0] {
    C_LOAD,
    C_STORE,
    C_ALU,
    C_BEQ,
    C_JMP,
    C_NONE
  } cls_e;

  // ALU second-operand selects
  localparam logic [1:0] SRCB_REG  = 2'b00;
  localparam logic [1:0] SRCB_FOUR = 2'b01;
  localparam logic [1:0] SRCB_IMM  = 2'b10;
  localparam logic [1:0] SRCB_OFS  = 2'b11;

  // ALU operation classes
  localparam logic [1:0] AOP_ADD  = 2'b00;
  localparam logic [1:0] AOP_SUB  = 2'b01;
  localparam logic [1:0] AOP_FUNC = 2'b10;

  // next-PC sources
  localparam logic [1:0] PCS_ALU = 2'b00;
  localparam logic [1:0] PCS_OUT = 2'b01;
  localparam logic [1:0] PCS_JMP = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel_alu;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       wb_from_mem;
    logic [1:0] pc_sel;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_wr;
    logic       rf_dst_rd;
  } ctl_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned      OP_W     = 6,
  parameter logic [OP_W-1:0]  OP_LOAD  = OP_W'(35),
  parameter logic [OP_W-1:0]  OP_STORE = OP_W'(43),
  parameter logic [OP_W-1:0]  OP_RTYPE = OP_W'(0),
  parameter logic [OP_W-1:0]  OP_BEQ   = OP_W'(4),
  parameter logic [OP_W-1:0]  OP_JMP   = OP_W'(2)
) (
  input  logic [OP_W-1:0] opcode,
  output cls_e            cls
);
  always_comb begin
    cls = C_NONE;
    if (opcode == OP_LOAD)       cls = C_LOAD;
    else if (opcode == OP_STORE) cls = C_STORE;
    else if (opcode == OP_RTYPE) cls = C_ALU;
    else if (opcode == OP_BEQ)   cls = C_BEQ;
    else if (opcode == OP_JMP)   cls = C_JMP;
  end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctrl_pkg::*;
(
  input  st_e  cur,
  input  cls_e cls,
  output st_e  nxt
);
  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        unique case (cls)
          C_LOAD, C_STORE: nxt = S_MADDR;
          C_ALU:           nxt = S_EXEC;
          C_BEQ:           nxt = S_BRANCH;
          C_JMP:           nxt = S_JUMP;
          default:         nxt = S_FETCH;
        endcase
      end
      S_MADDR: begin
        if (cls == C_LOAD)       nxt = S_MREAD;
        else if (cls == C_STORE) nxt = S_MWRITE;
        else                     nxt = S_FETCH;
      end
      S_MREAD:  nxt = S_MWB;
      S_EXEC:   nxt = S_RDONE;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import mc_ctrl_pkg::*;
(
  input  st_e  cur,
  output ctl_t ctl
);
  always_comb begin
    ctl = '0;
    unique case (cur)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_wr     = 1'b1;
        ctl.pc_wr     = 1'b1;
        ctl.alu_b_sel = SRCB_FOUR;
        ctl.alu_mode  = AOP_ADD;
        ctl.pc_sel    = PCS_ALU;
      end
      S_DECODE: begin
        ctl.alu_b_sel = SRCB_OFS;
        ctl.alu_mode  = AOP_ADD;
      end
      S_MADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = SRCB_IMM;
        ctl.alu_mode  = AOP_ADD;
      end
      S_MREAD: begin
        ctl.mem_rd       = 1'b1;
        ctl.addr_sel_alu = 1'b1;
      end
      S_MWB: begin
        ctl.rf_wr       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      S_MWRITE: begin
        ctl.mem_wr       = 1'b1;
        ctl.addr_sel_alu = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = SRCB_REG;
        ctl.alu_mode  = AOP_FUNC;
      end
      S_RDONE: begin
        ctl.rf_wr     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = SRCB_REG;
        ctl.alu_mode   = AOP_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_sel     = PCS_OUT;
      end
      S_JUMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_sel = PCS_JMP;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter int unsigned OP_W = 6,
  parameter int unsigned ST_W = ST_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] opcode,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic            addr_sel_alu,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            wb_from_mem,
  output logic [1:0]      pc_sel,
  output logic [1:0]      alu_mode,
  output logic            alu_a_sel,
  output logic [1:0]      alu_b_sel,
  output logic            rf_wr,
  output logic            rf_dst_rd,
  output logic [ST_W-1:0] state_o
);
  st_e  cur_q;
  st_e  nxt;
  cls_e cls;
  ctl_t ctl;

  mc_op_class #(.OP_W(OP_W)) u_class (
    .opcode (opcode),
    .cls    (cls)
  );

  mc_next_state u_next (
    .cur (cur_q),
    .cls (cls),
    .nxt (nxt)
  );

  mc_ctl_decode u_dec (
    .cur (cur_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= S_FETCH;
    else        cur_q <= nxt;
  end

  assign pc_wr        = ctl.pc_wr;
  assign pc_wr_cond   = ctl.pc_wr_cond;
  assign addr_sel_alu = ctl.addr_sel_alu;
  assign mem_rd       = ctl.mem_rd;
  assign mem_wr       = ctl.mem_wr;
  assign ir_wr        = ctl.ir_wr;
  assign wb_from_mem  = ctl.wb_from_mem;
  assign pc_sel       = ctl.pc_sel;
  assign alu_mode     = ctl.alu_mode;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign rf_wr        = ctl.rf_wr;
  assign rf_dst_rd    = ctl.rf_dst_rd;
  assign state_o      = ST_W'(cur_q);
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter int unsigned OP_W = 6,
  parameter int unsigned ST_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] opcode,
  input logic            pc_wr,
  input logic            ir_wr,
  input logic            mem_wr,
  input logic            rf_wr,
  input logic [ST_W-1:0] state_o
);
  logic op_known;
  assign op_known = (opcode == OP_W'(35)) || (opcode == OP_W'(43)) ||
                    (opcode == OP_W'(0))  || (opcode == OP_W'(4))  ||
                    (opcode == OP_W'(2));

  // R1
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= ST_W'(9));

  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_W'(0) |=> state_o == ST_W'(1));

  // R5
  load_read_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_W'(3) |=> state_o == ST_W'(4));

  // R6
  store_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_o == ST_W'(5) |=> state_o == ST_W'(0));

  // R8
  pc_write_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> (state_o == ST_W'(0) || state_o == ST_W'(9)));

  // R9
  unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_W'(1) && !op_known) |=> state_o == ST_W'(0));

  // R11
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ir_wr, mem_wr, rf_wr}) <= 1);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(.OP_W(OP_W), .ST_W(ST_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .opcode  (opcode),
  .pc_wr   (pc_wr),
  .ir_wr   (ir_wr),
  .mem_wr  (mem_wr),
  .rf_wr   (rf_wr),
  .state_o (state_o)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] op = 6'd0;
  logic       pc_wr, pc_wr_cond, addr_sel_alu, mem_rd, mem_wr, ir_wr, wb_from_mem;
  logic [1:0] pc_sel, alu_mode, alu_b_sel;
  logic       alu_a_sel, rf_wr, rf_dst_rd;
  logic [3:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mc_ctrl_fsm dut (
    .clk(clk), .rst_n(rst_n), .opcode(op),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel_alu(addr_sel_alu),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr), .wb_from_mem(wb_from_mem),
    .pc_sel(pc_sel), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_wr(rf_wr), .rf_dst_rd(rf_dst_rd), .state_o(state_o)
  );

  // packed order: pc_wr pc_wr_cond addr mem_rd mem_wr ir_wr wb pc_sel alu_mode a b rf_wr dst
  function automatic logic [15:0] pack(logic pw, logic pwc, logic ad, logic mr, logic mw,
                                       logic iw, logic wb, logic [1:0] ps, logic [1:0] am,
                                       logic sa, logic [1:0] sb, logic rw, logic rd);
    return {pw, pwc, ad, mr, mw, iw, wb, ps, am, sa, sb, rw, rd};
  endfunction

  // R11: every field not named for a state is zero
  function automatic logic [15:0] exp_ctl(int st);
    case (st)
      0: return pack(1,0,0,1,0,1,0,2'b00,2'b00,0,2'b01,0,0);
      1: return pack(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0);
      2: return pack(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0);
      3: return pack(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0);
      4: return pack(0,0,0,0,0,0,1,2'b00,2'b00,0,2'b00,1,0);
      5: return pack(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0);
      6: return pack(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0);
      7: return pack(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1);
      8: return pack(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0);
      9: return pack(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0);
      default: return '0;
    endcase
  endfunction

  function automatic int exp_next(int st, logic [5:0] o);
    case (st)
      0: return 1;
      1: case (o)
           6'h23, 6'h2B: return 2;
           6'h00:        return 6;
           6'h04:        return 8;
           6'h02:        return 9;
           default:      return 0;
         endcase
      2: return (o == 6'h23) ? 3 : (o == 6'h2B) ? 5 : 0;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(logic [5:0] o);
    case (o)
      6'h23: return 5;
      6'h2B: return 4;
      6'h00: return 4;
      6'h04: return 3;
      6'h02: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(int st, logic [5:0] o);
    case (st)
      0: return "R2";
      1: return (exp_len(o) == 2) ? "R9" : "R3";
      2: return "R4";
      3, 4: return "R5";
      5: return "R6";
      6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [5:0] pick_op(int idx);
    logic [5:0] dir [7] = '{6'h23, 6'h2B, 6'h00, 6'h04, 6'h02, 6'h3F, 6'h01};
    if (idx < 7) return dir[idx];
    case ($urandom % 7)
      0: return 6'h23;
      1: return 6'h2B;
      2: return 6'h00;
      3: return 6'h04;
      4: return 6'h02;
      default: return 6'($urandom);
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=0x%0h exp=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dut_ctl();
    return pack(pc_wr, pc_wr_cond, addr_sel_alu, mem_rd, mem_wr, ir_wr, wb_from_mem,
                pc_sel, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_rd);
  endfunction

  initial begin
    int st, prev, cnt, instr;
    logic [5:0] cur_op;
    bit started;
    void'($urandom(32'd1357));
    @(negedge clk);
    @(negedge clk);
    // R1: reset state and fetch vector
    check("R1", "reset state", int'(state_o), 0);
    check("R1", "reset vector", int'(dut_ctl()), int'(exp_ctl(0)));
    rst_n = 1'b1;
    st = 0; prev = 0; cnt = 0; instr = 0; started = 1'b0; cur_op = 6'd0;
    while (instr < 400) begin
      check(req_of(prev, cur_op), "state", int'(state_o), st);
      check(req_of(st, cur_op), "vector", int'(dut_ctl()), int'(exp_ctl(st)));
      if (st == 0) begin
        if (started)  // R10: cycles per instruction class
          check("R10", "cycles", cnt, exp_len(cur_op));
        cur_op = pick_op(instr);
        op = cur_op;
        instr++;
        cnt = 0;
        started = 1'b1;
      end
      cnt++;
      prev = st;
      st = exp_next(st, op);
      @(negedge clk);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R10 watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule